// File: doc/BRIEF.md
# Data Address Generator

This block forms the effective data-space address of a load or store for an 8-bit controller whose general register file has 32 entries. Decoded instruction fields arrive together with a request strobe. The block selects one of four ways to form the address: a short peripheral address, a full 16-bit address taken from a second instruction word, a pointer pair read from the top six general registers, or such a pointer plus a small unsigned offset. The result is registered and appears one cycle after the request.

Peripheral addresses are moved up past the 32 register-file locations in data space. Because the short field is six bits wide, only the first 64 peripheral slots can be reached this way. The slots above them can be reached only through the full-address and pointer modes. When the page option is enabled, a page byte is placed above the 16-bit value. Each pointer has its own page byte, and the full-address mode has one more. Offset addition wraps within the 16-bit page. A request that is not legal reports an error instead of an address.

Top module: `data_addr_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `addr_q`, `addr_vld` and `addr_err` are all zero.
- R2: Mode code 0 (peripheral) gives `addr_q` = `io_addr` + 0x20 with every upper bit zero. The result therefore lies between 0x20 and 0x5F and can never reach 0x60 or higher.
- R3: Mode code 1 (full address) gives `addr_q` = {`page_d`, `addr_word`}.
- R4: Mode code 2 (pointer) takes the low 16 bits from the pointer picked by `ptr_sel`. `ptr_sel` 0 picks `rf_ptr[15:0]` (registers 27:26), 1 picks `rf_ptr[31:16]` (registers 29:28) and 2 picks `rf_ptr[47:32]` (registers 31:30). In `rf_ptr`, register 26 sits in bits [7:0] and each following register occupies the next byte, so the higher-numbered register of a pair is the high byte.
- R5: In pointer modes the page byte comes from the selected pointer's own page input: `page_x` for `ptr_sel` 0, `page_y` for 1 and `page_z` for 2.
- R6: Mode code 3 (pointer plus offset) with `ptr_sel` 1 or 2 gives a low part equal to the pointer plus the unsigned `disp`, taken modulo 2^16. No carry passes into the page byte.
- R7: Mode code 3 with `ptr_sel` 0 is illegal and gives `addr_err` = 1 with `addr_q` = 0.
- R8: Mode codes 4 to 7 are illegal, and so is `ptr_sel` 3 in mode 2 or 3. Each gives `addr_err` = 1 with `addr_q` = 0.
- R9: `addr_vld` is high exactly in the cycle after a cycle with `req` high. `addr_q` and `addr_err` hold their values while `req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Decoded fields are valid this cycle |
| mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Pointer pair select |
| io_addr | input | 6 | Short peripheral address |
| addr_word | input | 16 | Second instruction word |
| disp | input | 6 | Unsigned pointer offset |
| rf_ptr | input | 48 | Registers 26 to 31, register 26 in the low byte |
| page_x | input | 8 | Page byte for pointer 0 |
| page_y | input | 8 | Page byte for pointer 1 |
| page_z | input | 8 | Page byte for pointer 2 |
| page_d | input | 8 | Page byte for full-address mode |
| addr_q | output | 24 | Registered effective address |
| addr_vld | output | 1 | Result valid |
| addr_err | output | 1 | Illegal request flag |

## Verification
The hardest case to reach is the offset wrap. The pointer must sit just below a 64K boundary, and the offset must carry out of bit 15 by exactly one step or stay just short of it. The stimulus loads a pointer of 0xFFF0 with a non-zero page byte and applies offsets of 0x0F and 0x10. The low part must land on 0xFFFF and then on 0x0000, and the page byte must stay unchanged in both cases. A separate directed step changes page and pointer inputs while no request is active, which shows that the registered result does not move.

// File: rtl/dag_pkg.sv
package dag_pkg;
   typedef enum logic [2:0] {
      AM_IO       = 3'd0,
      AM_DIRECT   = 3'd1,
      AM_IND      = 3'd2,
      AM_IND_DISP = 3'd3
   } amode_e;

   localparam int PTR_W   = 16;
   localparam int NUM_PTR = 3;
endpackage

// File: rtl/dag_ptr_pick.sv
module dag_ptr_pick
   import dag_pkg::*;
#(
   parameter int PAGE_W = 8
) (
   input  logic [NUM_PTR*PTR_W-1:0] rf_ptr,
   input  logic [1:0]               sel,
   input  logic [PAGE_W-1:0]        page_x,
   input  logic [PAGE_W-1:0]        page_y,
   input  logic [PAGE_W-1:0]        page_z,
   output logic [PTR_W-1:0]         ptr,
   output logic [PAGE_W-1:0]        page,
   output logic                     sel_bad
);
   logic [PTR_W-1:0] lane [NUM_PTR];

   for (genvar i = 0; i < NUM_PTR; i++) begin : g_lane
      assign lane[i] = rf_ptr[i*PTR_W +: PTR_W];
   end

   always_comb begin
      ptr     = '0;
      page    = '0;
      sel_bad = 1'b0;
      unique case (sel)
         2'd0: begin ptr = lane[0]; page = page_x; end
         2'd1: begin ptr = lane[1]; page = page_y; end
         2'd2: begin ptr = lane[2]; page = page_z; end
         default: sel_bad = 1'b1;
      endcase
   end
endmodule

// File: rtl/dag_addr_form.sv
module dag_addr_form
   import dag_pkg::*;
#(
   parameter int PAGE_W   = 8,
   parameter int IO_W     = 6,
   parameter int DISP_W   = 6,
   parameter int IO_BASE  = 32,
   parameter bit EXT_PAGE = 1'b1,
   localparam int ADDR_W  = EXT_PAGE ? PTR_W + PAGE_W : PTR_W
) (
   input  logic [2:0]        mode,
   input  logic [IO_W-1:0]   io_addr,
   input  logic [PTR_W-1:0]  addr_word,
   input  logic [DISP_W-1:0] disp,
   input  logic [PTR_W-1:0]  ptr,
   input  logic [PAGE_W-1:0] ptr_page,
   input  logic              sel_bad,
   input  logic              sel_is_x,
   input  logic [PAGE_W-1:0] page_d,
   output logic [ADDR_W-1:0] addr_d,
   output logic              err_d
);
   logic [PTR_W-1:0]  low;
   logic [PAGE_W-1:0] hi;
   logic              use_page;
   amode_e            am;

   assign am = amode_e'(mode);

   always_comb begin
      low      = '0;
      hi       = '0;
      use_page = 1'b0;
      err_d    = 1'b0;
      unique case (am)
         AM_IO:     low = PTR_W'(io_addr) + PTR_W'(IO_BASE);
         AM_DIRECT: begin low = addr_word; hi = page_d; use_page = 1'b1; end
         AM_IND: begin
            err_d = sel_bad;
            low = ptr; hi = ptr_page; use_page = 1'b1;
         end
         AM_IND_DISP: begin
            err_d = sel_bad | sel_is_x;
            low = ptr + PTR_W'(disp); hi = ptr_page; use_page = 1'b1;
         end
         default: err_d = 1'b1;
      endcase
   end

   if (EXT_PAGE) begin : g_paged
      assign addr_d = err_d ? '0 : {(use_page ? hi : {PAGE_W{1'b0}}), low};
   end else begin : g_flat
      logic unused_page;
      assign unused_page = ^{hi, use_page};
      assign addr_d = err_d ? '0 : low;
   end
endmodule

// File: rtl/dag_out_stage.sv
module dag_out_stage #(
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] addr_d,
   input  logic              err_d,
   output logic [ADDR_W-1:0] addr_q,
   output logic              vld_q,
   output logic              err_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         vld_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         vld_q <= req;
         if (req) begin
            addr_q <= addr_d;
            err_q  <= err_d;
         end
      end
   end
endmodule

// File: rtl/data_addr_gen.sv
module data_addr_gen
   import dag_pkg::*;
#(
   parameter int PAGE_W   = 8,
   parameter int IO_W     = 6,
   parameter int DISP_W   = 6,
   parameter int IO_BASE  = 32,
   parameter bit EXT_PAGE = 1'b1,
   localparam int ADDR_W  = EXT_PAGE ? PTR_W + PAGE_W : PTR_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req,
   input  logic [2:0]               mode,
   input  logic [1:0]               ptr_sel,
   input  logic [IO_W-1:0]          io_addr,
   input  logic [PTR_W-1:0]         addr_word,
   input  logic [DISP_W-1:0]        disp,
   input  logic [NUM_PTR*PTR_W-1:0] rf_ptr,
   input  logic [PAGE_W-1:0]        page_x,
   input  logic [PAGE_W-1:0]        page_y,
   input  logic [PAGE_W-1:0]        page_z,
   input  logic [PAGE_W-1:0]        page_d,
   output logic [ADDR_W-1:0]        addr_q,
   output logic                     addr_vld,
   output logic                     addr_err
);
   if (PAGE_W < 1 || PAGE_W > 16) begin : g_bad_page
      $error("data_addr_gen: PAGE_W out of range");
   end
   if (DISP_W < 1 || DISP_W > 15) begin : g_bad_disp
      $error("data_addr_gen: DISP_W out of range");
   end
   if (IO_BASE + (1 << IO_W) > (1 << PTR_W)) begin : g_bad_io
      $error("data_addr_gen: peripheral window exceeds page");
   end

   logic [PTR_W-1:0]  ptr;
   logic [PAGE_W-1:0] ptr_page;
   logic              sel_bad;
   logic [ADDR_W-1:0] addr_d;
   logic              err_d;

   dag_ptr_pick #(.PAGE_W(PAGE_W)) u_pick (
      .rf_ptr  (rf_ptr),
      .sel     (ptr_sel),
      .page_x  (page_x),
      .page_y  (page_y),
      .page_z  (page_z),
      .ptr     (ptr),
      .page    (ptr_page),
      .sel_bad (sel_bad)
   );

   dag_addr_form #(
      .PAGE_W(PAGE_W), .IO_W(IO_W), .DISP_W(DISP_W),
      .IO_BASE(IO_BASE), .EXT_PAGE(EXT_PAGE)
   ) u_form (
      .mode      (mode),
      .io_addr   (io_addr),
      .addr_word (addr_word),
      .disp      (disp),
      .ptr       (ptr),
      .ptr_page  (ptr_page),
      .sel_bad   (sel_bad),
      .sel_is_x  (ptr_sel == 2'd0),
      .page_d    (page_d),
      .addr_d    (addr_d),
      .err_d     (err_d)
   );

   dag_out_stage #(.ADDR_W(ADDR_W)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req),
      .addr_d (addr_d),
      .err_d  (err_d),
      .addr_q (addr_q),
      .vld_q  (addr_vld),
      .err_q  (addr_err)
   );
endmodule

// File: rtl/dag_chk.sv
module dag_chk #(
   parameter int ADDR_W = 24,
   parameter int IO_W   = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req,
   input logic [2:0]        mode,
   input logic [1:0]        ptr_sel,
   input logic [15:0]       addr_word,
   input logic [ADDR_W-1:0] addr_q,
   input logic              addr_vld,
   input logic              addr_err
);
   p_vld_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> addr_vld);
   p_no_vld_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !addr_vld);
   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> ($stable(addr_q) && $stable(addr_err)));
   p_io_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req && mode == 3'd0) |=> (!addr_err && addr_q >= ADDR_W'(32) && addr_q <= ADDR_W'(95)));
   p_direct_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req && mode == 3'd1) |=> (addr_q[15:0] == $past(addr_word) && !addr_err));
   p_x_disp_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req && mode == 3'd3 && ptr_sel == 2'd0) |=> (addr_err && addr_q == '0));
   p_bad_code_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req && (mode[2] || (mode[1] && ptr_sel == 2'd3))) |=> (addr_err && addr_q == '0));
   p_err_zero_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |-> addr_q == '0);
endmodule

bind data_addr_gen dag_chk #(.ADDR_W(ADDR_W), .IO_W(IO_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req       (req),
   .mode      (mode),
   .ptr_sel   (ptr_sel),
   .addr_word (addr_word),
   .addr_q    (addr_q),
   .addr_vld  (addr_vld),
   .addr_err  (addr_err)
);

// File: tb/sim_data_addr_gen.sv
module sim_data_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [2:0]  mode = '0;
   logic [1:0]  ptr_sel = '0;
   logic [5:0]  io_addr = '0;
   logic [15:0] addr_word = '0;
   logic [5:0]  disp = '0;
   logic [47:0] rf_ptr = 48'h8000_FFF0_1234;
   logic [7:0]  page_x = 8'h01, page_y = 8'h02, page_z = 8'h03, page_d = 8'h04;
   logic [23:0] addr_q;
   logic        addr_vld, addr_err;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   data_addr_gen u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .ptr_sel(ptr_sel),
      .io_addr(io_addr), .addr_word(addr_word), .disp(disp), .rf_ptr(rf_ptr),
      .page_x(page_x), .page_y(page_y), .page_z(page_z), .page_d(page_d),
      .addr_q(addr_q), .addr_vld(addr_vld), .addr_err(addr_err)
   );

   // {tag[4], mode[3], sel[2], io[6], word[16], disp[6], exp_addr[24], exp_err[1]}
   localparam logic [61:0] VEC [0:12] = '{
      {4'd2, 3'd0, 2'd0, 6'd0,  16'h0000, 6'd0,  24'h000020, 1'b0}, // R2 lowest
      {4'd2, 3'd0, 2'd0, 6'd63, 16'h0000, 6'd0,  24'h00005F, 1'b0}, // R2 highest
      {4'd3, 3'd1, 2'd0, 6'd0,  16'h0060, 6'd0,  24'h040060, 1'b0}, // R3 extended slot
      {4'd3, 3'd1, 2'd0, 6'd0,  16'hFFFF, 6'd0,  24'h04FFFF, 1'b0}, // R3
      {4'd4, 3'd2, 2'd0, 6'd0,  16'h0000, 6'd0,  24'h011234, 1'b0}, // R4 X
      {4'd4, 3'd2, 2'd1, 6'd0,  16'h0000, 6'd0,  24'h02FFF0, 1'b0}, // R4 Y
      {4'd5, 3'd2, 2'd2, 6'd0,  16'h0000, 6'd0,  24'h038000, 1'b0}, // R5 Z page
      {4'd6, 3'd3, 2'd1, 6'd0,  16'h0000, 6'd15, 24'h02FFFF, 1'b0}, // R6 no wrap
      {4'd6, 3'd3, 2'd1, 6'd0,  16'h0000, 6'd16, 24'h020000, 1'b0}, // R6 wrap
      {4'd6, 3'd3, 2'd2, 6'd0,  16'h0000, 6'd63, 24'h03803F, 1'b0}, // R6 max offset
      {4'd7, 3'd3, 2'd0, 6'd5,  16'h1111, 6'd9,  24'h000000, 1'b1}, // R7
      {4'd8, 3'd5, 2'd1, 6'd5,  16'h1111, 6'd9,  24'h000000, 1'b1}, // R8 mode
      {4'd8, 3'd2, 2'd3, 6'd5,  16'h1111, 6'd9,  24'h000000, 1'b1}  // R8 sel
   };

   task automatic chk(input int rq, input logic [23:0] ea, input logic ev, input logic ee);
      total++;
      if (addr_q !== ea || addr_vld !== ev || addr_err !== ee) begin
         bad++;
         $display("FAIL R%0d: addr=%h vld=%b err=%b expected addr=%h vld=%b err=%b",
                  rq, addr_q, addr_vld, addr_err, ea, ev, ee);
      end
   endtask

   task automatic issue(input logic [2:0] m, input logic [1:0] s, input logic [5:0] io,
                        input logic [15:0] w, input logic [5:0] d);
      @(negedge clk);
      mode = m; ptr_sel = s; io_addr = io; addr_word = w; disp = d; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run did not complete");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state, even with a request presented
      req = 1'b1; mode = 3'd1; addr_word = 16'hABCD;
      repeat (3) @(negedge clk);
      chk(1, 24'h0, 1'b0, 1'b0);
      req = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk(1, 24'h0, 1'b0, 1'b0);

      for (int i = 0; i < 13; i++) begin
         logic [61:0] v;
         v = VEC[i];
         issue(v[57:55], v[54:53], v[52:47], v[46:31], v[30:25]);
         chk(int'(v[61:58]), v[24:1], 1'b1, v[0]);
      end

      // R9: idle cycle after a result drops valid and holds address
      issue(3'd2, 2'd1, 6'd0, 16'h0, 6'd0);
      chk(9, 24'h02FFF0, 1'b1, 1'b0);
      page_y = 8'hAA; rf_ptr = 48'h0000_0001_0000; mode = 3'd1; addr_word = 16'h7777;
      @(negedge clk);
      chk(9, 24'h02FFF0, 1'b0, 1'b0);

      // R5: new page byte for Y is used on the next request
      rf_ptr = 48'h8000_FFF0_1234;
      issue(3'd2, 2'd1, 6'd0, 16'h0, 6'd0);
      chk(5, 24'hAAFFF0, 1'b1, 1'b0);

      // R6: wrap with the changed page still leaves page untouched
      issue(3'd3, 2'd1, 6'd0, 16'h0, 6'd31);
      chk(6, 24'hAA000F, 1'b1, 1'b0);

      // R9: back-to-back requests each produce a result
      @(negedge clk);
      mode = 3'd0; io_addr = 6'd1; req = 1'b1;
      @(negedge clk);
      chk(9, 24'h000021, 1'b1, 1'b0);
      mode = 3'd1; addr_word = 16'h0100;
      @(negedge clk);
      req = 1'b0;
      chk(9, 24'h040100, 1'b1, 1'b0);

      // R8: an illegal request followed by a legal one clears the error
      issue(3'd7, 2'd0, 6'd0, 16'h0, 6'd0);
      chk(8, 24'h0, 1'b1, 1'b1);
      issue(3'd0, 2'd0, 6'd10, 16'h0, 6'd0);
      chk(2, 24'h00002A, 1'b1, 1'b0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule